// File: doc/BRIEF.md
# Parallel-Bus Target Data-Phase Latency Guard

This block sits in the target side of a shared parallel bus. For every data phase of a transaction it decides whether the target completes the phase by asserting target-ready, adds a wait state by holding target-ready low, or ends the transaction with stop. It takes the transaction frame, the initiator-ready input and a local data-available input. It makes sure that no data phase runs past its clock budget. The first data phase may last longer than the later ones.

When a budget would be exceeded and the local side still has no data, the block asserts stop. If no data phase has completed yet, this is a retry. If at least one phase has completed, it is a disconnect. The kind of ending and the number of completed phases are held on outputs until the next transaction begins. A separate flag marks an initiator that has kept initiator-ready low for too long within one data phase. All control signals are active high. A transaction is in progress while frame or initiator-ready is high.

Top module: `bus_target_latency_guard`

## Requirements
- R1: After reset, target-ready, stop and the initiator-late flag are low, the termination code is 0 and the completed-phase count is 0.
- R2: Target-ready rises on the clock after data-available is sampled high during a data phase. Once raised, it stays high until initiator-ready is sampled high with it.
- R3: Each clock edge where initiator-ready and target-ready are both high completes a data phase. That edge increments the completed-phase count and starts the clock budget of the next phase from zero.
- R4: The first data phase of a transaction counts its clocks from the edge at which the transaction is first seen. It may contain at most FIRST_BUDGET-1 (15) wait states. If data is still unavailable, stop rises on clock FIRST_BUDGET (16) of the phase and the termination code becomes 1 (retry).
- R5: Every later data phase may contain at most LATER_BUDGET-1 (7) wait states. If data is still unavailable, stop rises on clock LATER_BUDGET (8) of that phase and the termination code becomes 2 (disconnect).
- R6: Stop stays high while frame is sampled high and falls on the clock after frame is sampled low. Target-ready is never high together with stop, and no further phase completes after stop.
- R7: The termination code (0 none, 1 retry, 2 disconnect) and the completed-phase count keep their values after a transaction ends. They return to 0 at the edge where the next transaction is first seen.
- R8: The initiator-late flag rises when initiator-ready is sampled low on LATER_BUDGET (8) edges within one data phase, not counting the edge at which the transaction is first seen. It stays high until the next transaction begins.
- R9: If frame and initiator-ready are both sampled low, the transaction is over. Target-ready is low on the next clock whatever data-available shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Transaction frame from the initiator |
| irdy_i | input | 1 | Initiator ready |
| data_avail_i | input | 1 | Local side can complete the current data phase |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Target requests termination |
| term_kind_o | output | 2 | 0 none, 1 retry, 2 disconnect |
| phase_cnt_o | output | PHASE_W | Data phases completed in the current or last transaction |
| init_late_o | output | 1 | Initiator exceeded its per-phase budget |

## Verification
On every cycle the assertions check the following. Stop and target-ready never overlap. Stop holds while frame stays high. Target-ready holds until it is accepted. A completion increments the count. A count of consecutive wait states, taken from the ports, never reaches the budget of the current phase. The termination code matches the completed-phase count when stop rises. The exact clock on which target-ready or stop appears can only be shown by the bench scenarios. They sweep the data delay across both budgets, from no wait to one past the limit. The same holds for the retention and clearing of the code and count between transactions, and for where the initiator-late threshold falls.

// File: rtl/bus_target_latency_guard.sv
module bus_target_latency_guard #(
  parameter int FIRST_BUDGET = 16,
  parameter int LATER_BUDGET = 8,
  parameter int PHASE_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_i,
  input  logic               irdy_i,
  input  logic               data_avail_i,
  output logic               trdy_o,
  output logic               stop_o,
  output logic [1:0]         term_kind_o,
  output logic [PHASE_W-1:0] phase_cnt_o,
  output logic               init_late_o
);
  localparam int CW = $clog2(FIRST_BUDGET + 1);
  localparam int IW = $clog2(LATER_BUDGET + 1);
  localparam logic [1:0] K_NONE  = 2'd0;
  localparam logic [1:0] K_RETRY = 2'd1;
  localparam logic [1:0] K_DISC  = 2'd2;
  localparam logic [CW-1:0] FIRST_LAST = CW'(FIRST_BUDGET - 1);
  localparam logic [CW-1:0] LATER_LAST = CW'(LATER_BUDGET - 1);
  localparam logic [CW-1:0] W_MAX = '1;
  localparam logic [IW-1:0] I_LIM = IW'(LATER_BUDGET);
  localparam logic [IW-1:0] I_MAX = '1;
  localparam logic [PHASE_W-1:0] P_MAX = '1;

  logic act_q, trdy_q, stop_q, late_q;
  logic [1:0] kind_q;
  logic [CW-1:0] wait_q;
  logic [IW-1:0] icnt_q;
  logic [PHASE_W-1:0] phase_q;

  logic active, start, complete, ending, held;
  logic [1:0] kind_base, kind_nx;
  logic [CW-1:0] wait_nx, budget_last;
  logic [IW-1:0] icnt_nx;
  logic [PHASE_W-1:0] phase_nx;
  logic new_stop, stop_nx, trdy_nx, late_nx;

  assign active   = frame_i | irdy_i;
  assign start    = active & ~act_q;
  assign complete = trdy_q & irdy_i;
  assign ending   = complete & ~frame_i;
  assign held     = trdy_q & ~complete;

  always_comb begin
    kind_base = start ? K_NONE : kind_q;

    if (start || complete)
      wait_nx = '0;
    else if (active && !trdy_q && kind_base == K_NONE && wait_q != W_MAX)
      wait_nx = wait_q + CW'(1);
    else
      wait_nx = wait_q;

    if (start)
      phase_nx = '0;
    else if (complete && phase_q != P_MAX)
      phase_nx = phase_q + PHASE_W'(1);
    else
      phase_nx = phase_q;

    budget_last = (phase_nx == '0) ? FIRST_LAST : LATER_LAST;

    new_stop = active && kind_base == K_NONE && !ending && !held &&
               !data_avail_i && wait_nx == budget_last;

    if (new_stop)
      kind_nx = (phase_nx == '0) ? K_RETRY : K_DISC;
    else
      kind_nx = kind_base;

    stop_nx = new_stop | (stop_q & frame_i);

    trdy_nx = !stop_nx && kind_nx == K_NONE &&
              (complete ? (frame_i & data_avail_i)
                        : (active & (trdy_q | data_avail_i)));

    if (start || complete)
      icnt_nx = '0;
    else if (act_q && active && !irdy_i && icnt_q != I_MAX)
      icnt_nx = icnt_q + IW'(1);
    else
      icnt_nx = icnt_q;

    late_nx = start ? 1'b0 : (late_q | (active & (icnt_nx >= I_LIM)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      trdy_q  <= 1'b0;
      stop_q  <= 1'b0;
      late_q  <= 1'b0;
      kind_q  <= K_NONE;
      wait_q  <= '0;
      icnt_q  <= '0;
      phase_q <= '0;
    end else begin
      act_q   <= active;
      trdy_q  <= trdy_nx;
      stop_q  <= stop_nx;
      late_q  <= late_nx;
      kind_q  <= kind_nx;
      wait_q  <= wait_nx;
      icnt_q  <= icnt_nx;
      phase_q <= phase_nx;
    end
  end

  assign trdy_o      = trdy_q;
  assign stop_o      = stop_q;
  assign term_kind_o = kind_q;
  assign phase_cnt_o = phase_q;
  assign init_late_o = late_q;

  logic       chk_act;
  logic [7:0] chk_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_act <= 1'b0;
      chk_len <= '0;
    end else begin
      chk_act <= frame_i | irdy_i;
      if (!(frame_i | irdy_i) || (irdy_i && trdy_o) || !chk_act)
        chk_len <= '0;
      else if (!trdy_o && !stop_o && term_kind_o == K_NONE && chk_len != 8'hFF)
        chk_len <= chk_len + 8'd1;
    end
  end

  AST_STOP_NO_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !trdy_o); // R6
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_o && frame_i) |=> stop_o); // R6
  AST_TRDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_o && !irdy_i && frame_i) |=> trdy_o); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_o && irdy_i && phase_cnt_o != P_MAX) |=> phase_cnt_o == $past(phase_cnt_o) + PHASE_W'(1)); // R3
  AST_WAIT_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    chk_len < ((phase_cnt_o == '0) ? 8'(FIRST_BUDGET) : 8'(LATER_BUDGET))); // R4 R5
  AST_STOP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_o) |-> term_kind_o == ((phase_cnt_o == '0) ? K_RETRY : K_DISC)); // R5
endmodule

// File: tb/test_bus_target_latency_guard.sv
module test_bus_target_latency_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_i = 1'b0, irdy_i = 1'b0, data_avail_i = 1'b0;
  logic trdy_o, stop_o, init_late_o;
  logic [1:0] term_kind_o;
  logic [7:0] phase_cnt_o;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  bus_target_latency_guard i_bus_target_latency_guard (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .irdy_i(irdy_i),
    .data_avail_i(data_avail_i), .trdy_o(trdy_o), .stop_o(stop_o),
    .term_kind_o(term_kind_o), .phase_cnt_o(phase_cnt_o), .init_late_o(init_late_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_txn(input int dfirst, input int dlater, input int nph);
    int p = 0, rel = 0, d = dfirst, lim = 16, done = 0, kind_exp = 0;
    bit fin = 0;
    frame_i = 1; irdy_i = 1; data_avail_i = (dfirst == 0);
    while (!fin) begin
      tick();
      rel++;
      if (rel == 1 && p == 0) begin
        check(term_kind_o == 0, "R7 code cleared", term_kind_o, 0);
        check(phase_cnt_o == 0, "R7 count cleared", phase_cnt_o, 0);
      end
      if (trdy_o) begin
        check(rel == d + 1 && d < lim, p == 0 ? "R4 trdy clock" : "R5 trdy clock", rel, d + 1);
        done++; p++;
        if (p == nph) begin
          frame_i = 0; data_avail_i = 0;
          tick();
          irdy_i = 0;
          fin = 1;
        end else begin
          d = dlater; lim = 8; rel = 0;
          data_avail_i = (d == 0);
        end
      end else if (stop_o) begin
        kind_exp = (p == 0) ? 1 : 2;
        check(rel == lim && d >= lim, p == 0 ? "R4 stop clock" : "R5 stop clock", rel, lim);
        check(term_kind_o == 2'(kind_exp), p == 0 ? "R4 retry code" : "R5 disconnect code",
              term_kind_o, kind_exp);
        data_avail_i = 1;
        for (int h = 0; h < 2; h++) begin
          tick();
          check(stop_o && !trdy_o, "R6 stop held", {30'd0, stop_o, trdy_o}, 2);
          check(phase_cnt_o == 8'(done), "R6 no completion", phase_cnt_o, done);
        end
        frame_i = 0; irdy_i = 0; data_avail_i = 0;
        tick();
        check(!stop_o, "R6 stop release", stop_o, 0);
        fin = 1;
      end else begin
        data_avail_i = (rel >= d);
        if (rel >= lim) begin
          check(0, "R4 R5 budget overrun", rel, lim);
          fin = 1;
        end
      end
    end
    tick(); tick();
    check(term_kind_o == 2'(kind_exp), "R7 code held", term_kind_o, kind_exp);
    check(phase_cnt_o == 8'(done), "R3 completed count", phase_cnt_o, done);
    check(!trdy_o && !stop_o, "R9 idle outputs", {30'd0, trdy_o, stop_o}, 0);
  endtask

  task automatic run_init(input int g);
    bit fin = 0;
    int rel = 0;
    frame_i = 1; irdy_i = 0; data_avail_i = 1;
    while (!fin) begin
      tick();
      rel++;
      if (rel > g) begin
        irdy_i = 1; frame_i = 0;
        tick();
        irdy_i = 0; data_avail_i = 0;
        fin = 1;
      end
    end
    tick();
    check(init_late_o == (g >= 8), "R8 initiator flag", init_late_o, int'(g >= 8));
    check(phase_cnt_o == 1, "R3 count after initiator waits", phase_cnt_o, 1);
    check(term_kind_o == 0, "R8 no termination", term_kind_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!trdy_o && !stop_o && !init_late_o, "R1 reset outputs",
          {29'd0, trdy_o, stop_o, init_late_o}, 0);
    check(term_kind_o == 0 && phase_cnt_o == 0, "R1 reset code and count",
          {22'd0, term_kind_o, phase_cnt_o}, 0);
    rst_n = 1;
    tick();

    for (int d = 0; d <= 17; d++) run_txn(d, 0, 1);
    for (int d = 0; d <= 9; d++) run_txn(0, d, 3);
    for (int d = 0; d <= 8; d += 4) run_txn(3, d, 2);
    for (int g = 0; g <= 10; g++) run_init(g);
    run_txn(20, 0, 1);
    run_init(9);
    check(init_late_o, "R8 flag held idle", init_late_o, 1);
    run_txn(0, 0, 1);
    check(!init_late_o, "R8 flag cleared by new transaction", init_late_o, 0);

    frame_i = 1; irdy_i = 0; data_avail_i = 0;
    tick(); tick();
    data_avail_i = 1;
    tick();
    check(trdy_o, "R2 trdy after data", trdy_o, 1);
    tick();
    check(trdy_o, "R2 trdy held", trdy_o, 1);
    frame_i = 0; irdy_i = 0;
    tick();
    check(!trdy_o, "R9 abort drops trdy", trdy_o, 0);
    check(phase_cnt_o == 0, "R9 abort no completion", phase_cnt_o, 0);
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule